// File: doc/BRIEF.md
# Paired-Block Interrupt Aggregator

This block gathers interrupt status for four status blocks, each serving two serial channels, and merges them onto two interrupt lines. Each block owns an 8-bit status register and an 8-bit mask register. Channel logic elsewhere raises per-channel set and clear pulses for transmit-ready, receive-ready and break. Block-level logic raises pulses for counter-ready and input-change. Software loads the masks through a register write port. Blocks 0 and 1 feed line 0, and blocks 2 and 3 feed line 1.

The block also holds a programmable vector byte. An interrupt acknowledge read returns this byte, and the lines are re-evaluated from the registered status on every cycle. The full status of all four blocks is visible on a flat output bus for the channel logic and the register read path. An asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `intr_pair_agg`

## Requirements
- R1: After reset all status, mask and vector registers are zero, both interrupt lines are low and the acknowledge data is zero.
- R2: Channel c owns block c/2. An even channel maps transmit-ready, receive-ready and break to bits 0, 1 and 2 of that block's status. An odd channel maps them to bits 4, 5 and 6. Block b's status appears on `status_flat[8*b+7:8*b]` in the cycle after the pulse.
- R3: A counter-ready pulse for a block sets its bit 3, and an input-change pulse sets its bit 7. Their clear pulses clear those bits.
- R4: A clear pulse clears its status bit. When a set pulse and a clear pulse hit the same bit in one cycle, the bit ends up set. A bit with neither pulse keeps its value.
- R5: Line n is high when (status AND mask) is non-zero for block 2n or block 2n+1, and low otherwise. The line follows a register change one cycle later.
- R6: A mask write with `mask_we` loads `mask_wdata` into the mask of block `mask_blk` only.
- R7: The break reset command clears bits 2 and 6 of block `brk_rst_blk` and leaves all other bits and blocks unchanged.
- R8: A vector write loads the vector byte only when `vec_addr` is 1. Writes at other addresses have no effect.
- R9: An acknowledge read at address 0 or 2 returns the vector byte on `ack_rdata` in the next cycle. A read at any other address returns zero. Between reads `ack_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_set | input | 8 | Per-channel transmit-ready set pulse |
| tx_clr | input | 8 | Per-channel transmit-ready clear pulse |
| rx_set | input | 8 | Per-channel receive-ready set pulse |
| rx_clr | input | 8 | Per-channel receive-ready clear pulse |
| brk_set | input | 8 | Per-channel break set pulse |
| brk_clr | input | 8 | Per-channel break clear pulse |
| cnt_set | input | 4 | Per-block counter-ready set pulse |
| cnt_clr | input | 4 | Per-block counter-ready clear pulse |
| ipc_set | input | 4 | Per-block input-change set pulse |
| ipc_clr | input | 4 | Per-block input-change clear pulse |
| brk_rst | input | 1 | Break reset command strobe |
| brk_rst_blk | input | 2 | Block addressed by the break reset |
| mask_we | input | 1 | Mask write strobe |
| mask_blk | input | 2 | Block addressed by the mask write |
| mask_wdata | input | 8 | Mask write data |
| vec_we | input | 1 | Vector space write strobe |
| vec_addr | input | 8 | Vector space write address |
| vec_wdata | input | 8 | Vector write data |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_addr | input | 8 | Acknowledge read address |
| ack_rdata | output | 8 | Acknowledge read data, registered |
| status_flat | output | 32 | Status of all blocks, block b at bits 8b+7..8b |
| irq | output | 2 | Interrupt lines, active high |

## Verification
Status bits, the mask and the vector byte are registered, so each is due one clock after its pulse or write strobe. The interrupt lines take one more stage and are due two clocks after the pulse or mask write that causes them. Acknowledge data is due one clock after the read strobe. The bench drives each stimulus on a falling edge for one cycle and samples on the next falling edge, or on the one after that for the lines, so every sample lands after exactly the register stages named above.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int STW       = 8;  // status / mask width
  localparam int KINDS     = 3;  // per-channel event kinds
  localparam int K_TX      = 0;
  localparam int K_RX      = 1;
  localparam int K_BRK     = 2;
  localparam int POS_CNT   = 3;
  localparam int ODD_SHIFT = 4;
  localparam int POS_IPC   = 7;

  function automatic int chan_pos(input int parity, input int kind);
    return parity * ODD_SHIFT + kind;
  endfunction
endpackage

// File: rtl/intr_stat_blk.sv
module intr_stat_blk
  import intr_agg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*KINDS-1:0]   ch_set,
  input  logic [2*KINDS-1:0]   ch_clr,
  input  logic                 cnt_set,
  input  logic                 cnt_clr,
  input  logic                 ipc_set,
  input  logic                 ipc_clr,
  input  logic                 brk_rst,
  input  logic                 mask_we,
  input  logic [STW-1:0]       mask_wdata,
  output logic [STW-1:0]       st_q,
  output logic [STW-1:0]       mk_q
);
  logic [STW-1:0] set_v, clr_v, st_d, mk_d;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < KINDS; k++) begin
        set_v[chan_pos(p, k)] = ch_set[p*KINDS+k];
        clr_v[chan_pos(p, k)] = ch_clr[p*KINDS+k];
      end
    end
    set_v[POS_CNT] = cnt_set;
    clr_v[POS_CNT] = cnt_clr;
    set_v[POS_IPC] = ipc_set;
    clr_v[POS_IPC] = ipc_clr;
    if (brk_rst) begin
      clr_v[chan_pos(0, K_BRK)] = 1'b1;
      clr_v[chan_pos(1, K_BRK)] = 1'b1;
    end
    // set has priority so no event is dropped
    st_d = (st_q & ~clr_v) | set_v;
    mk_d = mask_we ? mask_wdata : mk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      mk_q <= '0;
    end else begin
      st_q <= st_d;
      mk_q <= mk_d;
    end
  end
endmodule

// File: rtl/intr_line_merge.sv
module intr_line_merge
  import intr_agg_pkg::*;
#(
  parameter int NBLK = 4,
  localparam int NLINE = NBLK / 2
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NBLK*STW-1:0]   st_flat,
  input  logic [NBLK*STW-1:0]   mk_flat,
  output logic [NLINE-1:0]      irq_q
);
  logic [NLINE-1:0] irq_d;

  for (genvar n = 0; n < NLINE; n++) begin : g_line
    logic [STW-1:0] pend_lo, pend_hi;
    assign pend_lo  = st_flat[(2*n)*STW +: STW]   & mk_flat[(2*n)*STW +: STW];
    assign pend_hi  = st_flat[(2*n+1)*STW +: STW] & mk_flat[(2*n+1)*STW +: STW];
    assign irq_d[n] = |{pend_lo, pend_hi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/intr_vec_ack.sv
module intr_vec_ack #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] VEC_WADDR = 1,
  parameter logic [AW-1:0] ACK0_ADDR = 0,
  parameter logic [AW-1:0] ACK1_ADDR = 2
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vec_we,
  input  logic [AW-1:0] vec_addr,
  input  logic [DW-1:0] vec_wdata,
  input  logic          ack_rd,
  input  logic [AW-1:0] ack_addr,
  output logic [DW-1:0] vec_q,
  output logic [DW-1:0] rdata_q
);
  logic          vec_en, rd_hit;
  logic [DW-1:0] vec_d, rdata_d;

  always_comb begin
    vec_en  = vec_we && (vec_addr == VEC_WADDR);
    rd_hit  = (ack_addr == ACK0_ADDR) || (ack_addr == ACK1_ADDR);
    vec_d   = vec_en ? vec_wdata : vec_q;
    rdata_d = rdata_q;
    if (ack_rd) rdata_d = rd_hit ? vec_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      rdata_q <= '0;
    end else begin
      vec_q   <= vec_d;
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/intr_pair_agg.sv
module intr_pair_agg
  import intr_agg_pkg::*;
#(
  parameter int NBLK = 4,
  parameter int DW   = 8,
  parameter int AW   = 8,
  localparam int NCH   = 2 * NBLK,
  localparam int NLINE = NBLK / 2,
  localparam int BW    = $clog2(NBLK)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       tx_set,
  input  logic [NCH-1:0]       tx_clr,
  input  logic [NCH-1:0]       rx_set,
  input  logic [NCH-1:0]       rx_clr,
  input  logic [NCH-1:0]       brk_set,
  input  logic [NCH-1:0]       brk_clr,
  input  logic [NBLK-1:0]      cnt_set,
  input  logic [NBLK-1:0]      cnt_clr,
  input  logic [NBLK-1:0]      ipc_set,
  input  logic [NBLK-1:0]      ipc_clr,
  input  logic                 brk_rst,
  input  logic [BW-1:0]        brk_rst_blk,
  input  logic                 mask_we,
  input  logic [BW-1:0]        mask_blk,
  input  logic [STW-1:0]       mask_wdata,
  input  logic                 vec_we,
  input  logic [AW-1:0]        vec_addr,
  input  logic [DW-1:0]        vec_wdata,
  input  logic                 ack_rd,
  input  logic [AW-1:0]        ack_addr,
  output logic [DW-1:0]        ack_rdata,
  output logic [NBLK*STW-1:0]  status_flat,
  output logic [NLINE-1:0]     irq
);
  logic                rst_meta_n, rst_sync_n;
  logic [NBLK*STW-1:0] mask_flat;
  logic [DW-1:0]       vec_q;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [2*KINDS-1:0] cs, cc;
    assign cs = {brk_set[2*b+1], rx_set[2*b+1], tx_set[2*b+1],
                 brk_set[2*b],   rx_set[2*b],   tx_set[2*b]};
    assign cc = {brk_clr[2*b+1], rx_clr[2*b+1], tx_clr[2*b+1],
                 brk_clr[2*b],   rx_clr[2*b],   tx_clr[2*b]};
    intr_stat_blk u_blk (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .ch_set     (cs),
      .ch_clr     (cc),
      .cnt_set    (cnt_set[b]),
      .cnt_clr    (cnt_clr[b]),
      .ipc_set    (ipc_set[b]),
      .ipc_clr    (ipc_clr[b]),
      .brk_rst    (brk_rst && (brk_rst_blk == BW'(b))),
      .mask_we    (mask_we && (mask_blk == BW'(b))),
      .mask_wdata (mask_wdata),
      .st_q       (status_flat[b*STW +: STW]),
      .mk_q       (mask_flat[b*STW +: STW])
    );
  end

  intr_line_merge #(.NBLK(NBLK)) u_merge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .st_flat (status_flat),
    .mk_flat (mask_flat),
    .irq_q   (irq)
  );

  intr_vec_ack #(.DW(DW), .AW(AW)) u_vec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .vec_we    (vec_we),
    .vec_addr  (vec_addr),
    .vec_wdata (vec_wdata),
    .ack_rd    (ack_rd),
    .ack_addr  (ack_addr),
    .vec_q     (vec_q),
    .rdata_q   (ack_rdata)
  );
endmodule

// File: rtl/intr_pair_agg_chk.sv
module intr_pair_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  tx_set,
  input logic        brk_rst,
  input logic [1:0]  brk_rst_blk,
  input logic [7:0]  brk_set,
  input logic        vec_we,
  input logic [7:0]  vec_addr,
  input logic [7:0]  vec_q,
  input logic        ack_rd,
  input logic [7:0]  ack_addr,
  input logic [7:0]  ack_rdata,
  input logic [31:0] status_flat,
  input logic [31:0] mask_flat,
  input logic [1:0]  irq
);
  // R4: a set pulse always leaves its bit set
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tx_set[0])) |-> status_flat[0]);

  // R7: break reset clears both break bits of block 0
  p_brk_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(brk_rst) && ($past(brk_rst_blk) == 2'd0)
     && !$past(brk_set[0]) && !$past(brk_set[1]))
    |-> (!status_flat[2] && !status_flat[6]));

  // R8: vector holds unless written at its address
  p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !($past(vec_we) && ($past(vec_addr) == 8'd1)))
    |-> $stable(vec_q));

  // R9: reads outside the acknowledge addresses return zero
  p_ack_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ack_rd) && ($past(ack_addr) != 8'd0)
     && ($past(ack_addr) != 8'd2)) |-> (ack_rdata == 8'd0));

  // R5: masked-off status never raises a line
  p_no_mask_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(mask_flat) == 32'd0)) |-> (irq == 2'b00));

  // R5: line 0 follows the pending status of blocks 0 and 1
  p_line0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
    (irq[0] == $past(|(status_flat[15:0] & mask_flat[15:0]))));
endmodule

bind intr_pair_agg intr_pair_agg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tx_set      (tx_set),
  .brk_rst     (brk_rst),
  .brk_rst_blk (brk_rst_blk),
  .brk_set     (brk_set),
  .vec_we      (vec_we),
  .vec_addr    (vec_addr),
  .vec_q       (vec_q),
  .ack_rd      (ack_rd),
  .ack_addr    (ack_addr),
  .ack_rdata   (ack_rdata),
  .status_flat (status_flat),
  .mask_flat   (mask_flat),
  .irq         (irq)
);

// File: tb/test_intr_pair_agg.sv
module test_intr_pair_agg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  tx_set, tx_clr, rx_set, rx_clr, brk_set, brk_clr;
  logic [3:0]  cnt_set, cnt_clr, ipc_set, ipc_clr;
  logic        brk_rst, mask_we, vec_we, ack_rd;
  logic [1:0]  brk_rst_blk, mask_blk;
  logic [7:0]  mask_wdata, vec_addr, vec_wdata, ack_addr, ack_rdata;
  logic [31:0] status_flat;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intr_pair_agg i_intr_pair_agg (
    .clk(clk), .rst_n(rst_n),
    .tx_set(tx_set), .tx_clr(tx_clr), .rx_set(rx_set), .rx_clr(rx_clr),
    .brk_set(brk_set), .brk_clr(brk_clr),
    .cnt_set(cnt_set), .cnt_clr(cnt_clr), .ipc_set(ipc_set), .ipc_clr(ipc_clr),
    .brk_rst(brk_rst), .brk_rst_blk(brk_rst_blk),
    .mask_we(mask_we), .mask_blk(mask_blk), .mask_wdata(mask_wdata),
    .vec_we(vec_we), .vec_addr(vec_addr), .vec_wdata(vec_wdata),
    .ack_rd(ack_rd), .ack_addr(ack_addr), .ack_rdata(ack_rdata),
    .status_flat(status_flat), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    tx_set = '0; tx_clr = '0; rx_set = '0; rx_clr = '0;
    brk_set = '0; brk_clr = '0;
    cnt_set = '0; cnt_clr = '0; ipc_set = '0; ipc_clr = '0;
    brk_rst = 1'b0; brk_rst_blk = '0;
    mask_we = 1'b0; mask_blk = '0; mask_wdata = '0;
    vec_we = 1'b0; vec_addr = '0; vec_wdata = '0;
    ack_rd = 1'b0; ack_addr = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic write_mask(input logic [1:0] b, input logic [7:0] m);
    mask_we = 1'b1; mask_blk = b; mask_wdata = m;
    step();
  endtask

  task automatic ack_read(input logic [7:0] a);
    ack_rd = 1'b1; ack_addr = a;
    step();
  endtask

  task automatic t_reset();
    check("R1 status", status_flat, 32'h0);
    check("R1 irq", {30'h0, irq}, 32'h0);
    check("R1 ack", {24'h0, ack_rdata}, 32'h0);
    ack_read(8'd0);
    check("R1 vector zero", {24'h0, ack_rdata}, 32'h0);
  endtask

  task automatic t_map();
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] e;
        e = 32'h1 << (8 * (c / 2) + 4 * (c % 2) + k);
        if (k == 0) tx_set[c] = 1'b1;
        else if (k == 1) rx_set[c] = 1'b1;
        else brk_set[c] = 1'b1;
        step();
        check("R2 set map", status_flat, e);
        if (k == 0) tx_clr[c] = 1'b1;
        else if (k == 1) rx_clr[c] = 1'b1;
        else brk_clr[c] = 1'b1;
        step();
        check("R4 clear", status_flat, 32'h0);
      end
    end
  endtask

  task automatic t_block_bits();
    cnt_set[1] = 1'b1;
    step();
    check("R3 counter bit", status_flat, 32'h0000_0800);
    ipc_set[3] = 1'b1;
    step();
    check("R3 input change bit", status_flat, 32'h8000_0800);
    cnt_clr[1] = 1'b1; ipc_clr[3] = 1'b1;
    step();
    check("R3 clear", status_flat, 32'h0);
  endtask

  task automatic t_set_wins();
    rx_set[5] = 1'b1; rx_clr[5] = 1'b1;
    step();
    check("R4 set wins", status_flat, 32'h0020_0000);
    step();
    check("R4 hold", status_flat, 32'h0020_0000);
    rx_clr[5] = 1'b1;
    step();
    check("R4 clear after", status_flat, 32'h0);
  endtask

  task automatic t_irq();
    rx_set[2] = 1'b1;              // block 1 bit 1
    step();
    step();
    check("R5 unmasked low", {30'h0, irq}, 32'h0);
    write_mask(2'd1, 8'h02);
    check("R6 mask not yet at line", {30'h0, irq}, 32'h0);
    step();
    check("R5 line0 high", {30'h0, irq}, 32'h1);
    write_mask(2'd0, 8'hFF);        // other block mask must not change block 1
    write_mask(2'd0, 8'h00);
    write_mask(2'd1, 8'h01);
    step();
    check("R6 mask replaced", {30'h0, irq}, 32'h0);
    rx_clr[2] = 1'b1;
    step();
    write_mask(2'd3, 8'h80);
    ipc_set[3] = 1'b1;
    step();
    step();
    check("R5 line1 only", {30'h0, irq}, 32'h2);
    ipc_clr[3] = 1'b1;
    step();
    step();
    check("R5 line1 drops", {30'h0, irq}, 32'h0);
    write_mask(2'd1, 8'h00);
    write_mask(2'd3, 8'h00);
  endtask

  task automatic t_brk_rst();
    brk_set[4] = 1'b1; brk_set[5] = 1'b1; tx_set[4] = 1'b1; brk_set[0] = 1'b1;
    step();
    check("R7 setup", status_flat, 32'h0045_0004);
    brk_rst = 1'b1; brk_rst_blk = 2'd2;
    step();
    check("R7 break reset", status_flat, 32'h0001_0004);
    brk_rst = 1'b1; brk_rst_blk = 2'd0;
    step();
    check("R7 block 0", status_flat, 32'h0001_0000);
    tx_clr[4] = 1'b1;
    step();
  endtask

  task automatic t_vector();
    vec_we = 1'b1; vec_addr = 8'd1; vec_wdata = 8'hA5;
    step();
    ack_read(8'd0);
    check("R9 ack addr 0", {24'h0, ack_rdata}, 32'hA5);
    step();
    check("R9 hold", {24'h0, ack_rdata}, 32'hA5);
    ack_read(8'd3);
    check("R9 other addr", {24'h0, ack_rdata}, 32'h0);
    vec_we = 1'b1; vec_addr = 8'd0; vec_wdata = 8'h3C;
    step();
    ack_read(8'd2);
    check("R8 wrong addr ignored", {24'h0, ack_rdata}, 32'hA5);
    vec_we = 1'b1; vec_addr = 8'd1; vec_wdata = 8'h5A;
    step();
    ack_read(8'd2);
    check("R9 ack addr 2", {24'h0, ack_rdata}, 32'h5A);
    ack_read(8'd1);
    check("R9 addr 1 read", {24'h0, ack_rdata}, 32'h0);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_map();
    t_block_bits();
    t_set_wins();
    t_irq();
    t_brk_rst();
    t_vector();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule